// File: doc/BRIEF.md
# Cascaded Free-Running Timebase Counter

This block is a free-running timebase that is twice as wide as its basic counter channel. Two up-counters, each `CNT_W` bits wide, are chained. The low channel steps on ticks from a selectable power-of-two prescaler of the system clock. It drives a square-wave output that goes high when its count reaches zero and low when it reaches half scale.

Each rising edge of that wave advances the high channel by one. The rising edge is detected inside the system clock domain, so the high channel steps on the same clock edge on which the low channel wraps. A single sync command clears both channels and the prescaler phase together.

When the `NATIVE` parameter is set, one channel of full `2*CNT_W` width supplies the whole value, and the second channel stays idle. Each channel has its own start and stop commands. Software reads the low half, the high half or the composed value. A reader that samples the halves separately rereads the high half and retries if it has changed.

Top module: `cascade_timebase`

## Requirements
- R1: While `rst_n` is low, all outputs are zero and both channels are stopped. The internal reset is released two rising edges after `rst_n` rises. No count changes until a start command arrives.
- R2: A running low channel adds one to `lo_count` on each prescaler tick and wraps from all ones to zero. No compare value resets it.
- R3: With `presc_sel` = s, the prescaler ticks once every 2^s clocks. Its phase counter runs freely and is cleared by sync, so after a sync the first step occurs on the 2^s-th rising edge.
- R4: `wav_out[i]`, the wave output of channel i, becomes 1 when that channel's count steps to zero and becomes 0 when it steps to 2^(W-1), where W is the channel width. At all other times it holds its value.
- R5: A running high channel adds one to `hi_count` on exactly the edge on which the low channel steps from all ones to zero, which is a rising edge of `wav_out[0]`. At no other time does it change, except through sync.
- R6: In cascaded mode, `time_value` equals `{hi_count, lo_count}`.
- R7: A sync command clears both counts, both wave outputs and the prescaler phase at the next edge. It takes priority over a step and leaves the started or stopped state of each channel unchanged.
- R8: `clk_stop[i]` freezes channel i and `clk_start[i]` resumes it without clearing the count. Stop wins when both arrive together. A command changes stepping only from the next clock on.
- R9: `rollover` is high for exactly the one cycle whose closing edge takes `time_value` from all ones to zero.
- R10: With `NATIVE`=1, one counter of `2*CNT_W` bits, controlled by the channel 0 commands, supplies `time_value`, and `lo_count` is its low half. `hi_count` and `wav_out[1]` stay 0, and `clk_start[1]` and `clk_stop[1]` have no effect.
- R11: The high half never lags the low half. Whenever `hi_count` changes without a sync, `time_value` has stepped by exactly one. A reader that samples the high half, then the low half, then the high half again on successive cycles, and retries when the two high samples differ, obtains the `time_value` that was present when the low half was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync_cmd | input | 1 | Clears both channels and the prescaler phase together |
| clk_start | input | 2 | Per-channel start command (bit 0 low channel, bit 1 high channel) |
| clk_stop | input | 2 | Per-channel stop command; wins over start |
| presc_sel | input | SEL_W | Prescaler select, divide by 2^presc_sel |
| lo_count | output | CNT_W | Low channel count |
| hi_count | output | CNT_W | High channel count (0 in native mode) |
| wav_out | output | 2 | Wave outputs of the two channels |
| time_value | output | 2*CNT_W | Composed timebase value |
| rollover | output | 1 | One-cycle pulse before the full timebase wraps |

## Verification
The assertions check several behaviours on every cycle. The low count moves by at most one per edge. A sync clears everything at the next edge. A stop leaves the count frozen from the second edge on. The wave output rises only on a zero count. A change in the high half coincides with a one-step move of the composed value, and a rollover pulse is followed by a zero timebase. Other behaviours need the bench's scenarios to show them: the exact prescaler intervals after a sync, resuming without loss after a stop, the high half holding while its channel is stopped, the idle second channel in native mode, and the retrying read across a low-half wrap.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int unsigned CH_LO = 0;
  localparam int unsigned CH_HI = 1;

  typedef struct packed {
    logic start;
    logic stop;
  } run_cmd_t;
endpackage

// File: rtl/ctb_rst_sync.sv
module ctb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sr_q <= '0;
    else           sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sr_q[STAGES-1];
endmodule

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PH_W = (1 << SEL_W) - 1;

  logic [PH_W-1:0] ph_q, ph_d, mask;

  // low sel bits of the phase all ones marks one tick per 2^sel clocks
  assign mask = ~({PH_W{1'b1}} << sel);
  assign tick = (ph_q & mask) == mask;

  always_comb begin
    if (sync_clr) ph_d = '0;
    else          ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/ctb_channel.sv
module ctb_channel
  import ctb_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_clr,
  input  run_cmd_t     cmd,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wave,
  output logic         wave_rise
);
  localparam logic [W-1:0] CMP_SET = '0;
  localparam logic [W-1:0] CMP_CLR = {1'b1, {(W-1){1'b0}}};

  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         wave_q, wave_d;
  logic         adv, cnt_en;

  always_comb begin
    run_d = run_q;
    if (cmd.stop)       run_d = 1'b0;
    else if (cmd.start) run_d = 1'b1;

    adv    = run_q & step;
    cnt_en = adv | sync_clr;
    cnt_d  = cnt_q;
    wave_d = wave_q;
    if (sync_clr) begin
      cnt_d  = '0;
      wave_d = 1'b0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d == CMP_SET)      wave_d = 1'b1;
      else if (cnt_d == CMP_CLR) wave_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        wave_q <= wave_d;
      end
    end
  end

  assign count     = cnt_q;
  assign wave      = wave_q;
  // next-state rise: the chained channel steps on the same edge as the wrap
  assign wave_rise = wave_d & ~wave_q;
endmodule

// File: rtl/cascade_timebase.sv
module cascade_timebase
  import ctb_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 2,
  parameter bit          NATIVE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_cmd,
  input  logic [1:0]         clk_start,
  input  logic [1:0]         clk_stop,
  input  logic [SEL_W-1:0]   presc_sel,
  output logic [CNT_W-1:0]   lo_count,
  output logic [CNT_W-1:0]   hi_count,
  output logic [1:0]         wav_out,
  output logic [2*CNT_W-1:0] time_value,
  output logic               rollover
);
  localparam int unsigned TB_W = 2 * CNT_W;

  logic     rst_int_n;
  logic     presc_tick;
  run_cmd_t cmd_lo, cmd_hi;

  assign cmd_lo.start = clk_start[CH_LO];
  assign cmd_lo.stop  = clk_stop[CH_LO];
  assign cmd_hi.start = clk_start[CH_HI];
  assign cmd_hi.stop  = clk_stop[CH_HI];

  ctb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  ctb_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sync_clr (sync_cmd),
    .sel      (presc_sel),
    .tick     (presc_tick)
  );

  generate
    if (NATIVE) begin : g_native
      logic [TB_W-1:0] wide_cnt;
      logic            wide_wave, wide_rise;
      logic            unused_hi_cmd;

      ctb_channel #(.W(TB_W)) u_wide (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .sync_clr  (sync_cmd),
        .cmd       (cmd_lo),
        .step      (presc_tick),
        .count     (wide_cnt),
        .wave      (wide_wave),
        .wave_rise (wide_rise)
      );

      assign unused_hi_cmd = cmd_hi.start ^ cmd_hi.stop;
      assign lo_count      = wide_cnt[CNT_W-1:0];
      assign hi_count      = '0;
      assign wav_out       = {1'b0, wide_wave};
      assign time_value    = wide_cnt;
      assign rollover      = wide_rise;
    end else begin : g_cascade
      logic [CNT_W-1:0] lo_cnt, hi_cnt;
      logic             lo_wave, lo_rise, hi_wave, hi_rise;

      ctb_channel #(.W(CNT_W)) u_lo (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .sync_clr  (sync_cmd),
        .cmd       (cmd_lo),
        .step      (presc_tick),
        .count     (lo_cnt),
        .wave      (lo_wave),
        .wave_rise (lo_rise)
      );

      ctb_channel #(.W(CNT_W)) u_hi (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .sync_clr  (sync_cmd),
        .cmd       (cmd_hi),
        .step      (lo_rise),
        .count     (hi_cnt),
        .wave      (hi_wave),
        .wave_rise (hi_rise)
      );

      assign lo_count   = lo_cnt;
      assign hi_count   = hi_cnt;
      assign wav_out    = {hi_wave, lo_wave};
      assign time_value = {hi_cnt, lo_cnt};
      assign rollover   = hi_rise;
    end
  endgenerate
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          NATIVE = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_cmd,
  input logic               stop_lo,
  input logic [CNT_W-1:0]   lo_count,
  input logic [CNT_W-1:0]   hi_count,
  input logic               wav_lo,
  input logic [2*CNT_W-1:0] time_value,
  input logic               rollover
);
  // R2: low half moves by at most one per edge
  a_r2_lo_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_cmd |=> (lo_count == $past(lo_count)) || (lo_count == $past(lo_count) + 1'b1));

  // R7: sync clears both halves and the low wave
  a_r7_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cmd |=> (lo_count == '0) && (hi_count == '0) && !wav_lo);

  // R8: a stopped channel is frozen from the second edge on
  a_r8_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_lo ##1 !sync_cmd) |=> $stable(lo_count));

  // R4: wave rises only on a zero count
  a_r4_wave_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wav_lo) |-> (lo_count == '0));

  // R9: rollover pulse precedes a zero timebase
  a_r9_rollover_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (time_value == '0));

  generate
    if (NATIVE) begin : g_native_chk
      // R11: the single wide counter only holds or steps by one
      a_r11_coherent_step: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_cmd |=> (time_value == $past(time_value)) ||
                      (time_value == $past(time_value) + 1'b1));
    end else begin : g_cascade_chk
      // R5: high half changes only together with a low wrap to zero
      a_r5_hi_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_cmd |=> (hi_count == $past(hi_count)) ||
                      ((lo_count == '0) && (hi_count == $past(hi_count) + 1'b1)));
      // R11: a high-half change is a one-step move of the whole value
      a_r11_coherent_step: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_cmd |=> (hi_count == $past(hi_count)) ||
                      (time_value == $past(time_value) + 1'b1));
    end
  endgenerate
endmodule

bind cascade_timebase ctb_checker #(.CNT_W(CNT_W), .NATIVE(NATIVE)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_cmd   (sync_cmd),
  .stop_lo    (clk_stop[0]),
  .lo_count   (lo_count),
  .hi_count   (hi_count),
  .wav_lo     (wav_out[0]),
  .time_value (time_value),
  .rollover   (rollover)
);

// File: tb/tb_cascade_timebase.sv
module tb_cascade_timebase;
  localparam int W  = 8;
  localparam int SW = 2;

  logic          clk, rst_n, sync_cmd;
  logic [1:0]    clk_start, clk_stop;
  logic [SW-1:0] presc_sel;

  logic [W-1:0]   lo_c, hi_c, lo_n, hi_n;
  logic [1:0]     wav_c, wav_n;
  logic [2*W-1:0] tv_c, tv_n;
  logic           roll_c, roll_n;

  int checks, fails, cyc, n_roll, n_nroll;
  bit done;

  cascade_timebase #(.CNT_W(W), .SEL_W(SW), .NATIVE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sync_cmd(sync_cmd), .clk_start(clk_start),
    .clk_stop(clk_stop), .presc_sel(presc_sel), .lo_count(lo_c), .hi_count(hi_c),
    .wav_out(wav_c), .time_value(tv_c), .rollover(roll_c));

  cascade_timebase #(.CNT_W(W), .SEL_W(SW), .NATIVE(1'b1)) dut_native (
    .clk(clk), .rst_n(rst_n), .sync_cmd(sync_cmd), .clk_start(clk_start),
    .clk_stop(clk_stop), .presc_sel(presc_sel), .lo_count(lo_n), .hi_count(hi_n),
    .wav_out(wav_n), .time_value(tv_n), .rollover(roll_n));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model built from the requirements ----------------
  logic [1:0]     m_rs;
  logic [2:0]     m_ps;
  logic           m_run0, m_run1, n_run;
  logic [W-1:0]   m_lo, m_hi;
  logic           m_wav0, m_wav1, n_wav;
  logic [2*W-1:0] n_cnt;

  function automatic logic tick_of(input logic [2:0] ph, input logic [SW-1:0] s);
    logic [2:0] m;
    m = 3'((1 << s) - 1);
    return (ph & m) == m;
  endfunction

  logic m_tick, m_st0, m_st1, m_stn, exp_roll, exp_nroll;
  assign m_tick    = tick_of(m_ps, presc_sel);
  assign m_st0     = m_run0 && m_tick;
  assign m_st1     = m_run1 && m_st0 && (m_lo == '1);
  assign m_stn     = n_run && m_tick;
  assign exp_roll  = !sync_cmd && m_st1 && (m_hi == '1);
  assign exp_nroll = !sync_cmd && m_stn && (n_cnt == '1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rs <= 2'b00;
    else        m_rs <= {m_rs[0], 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_rs[1]) begin
      m_ps <= '0; m_run0 <= 0; m_run1 <= 0; n_run <= 0;
      m_lo <= '0; m_hi <= '0; m_wav0 <= 0; m_wav1 <= 0; n_wav <= 0; n_cnt <= '0;
    end else begin
      m_run0 <= clk_stop[0] ? 1'b0 : clk_start[0] ? 1'b1 : m_run0;
      m_run1 <= clk_stop[1] ? 1'b0 : clk_start[1] ? 1'b1 : m_run1;
      n_run  <= clk_stop[0] ? 1'b0 : clk_start[0] ? 1'b1 : n_run;
      if (sync_cmd) begin
        m_ps <= '0; m_lo <= '0; m_hi <= '0; m_wav0 <= 0; m_wav1 <= 0; n_cnt <= '0; n_wav <= 0;
      end else begin
        m_ps <= m_ps + 1'b1;
        if (m_st0) begin
          m_lo <= m_lo + 1'b1;
          if (m_lo == 8'hFF) m_wav0 <= 1'b1; else if (m_lo == 8'h7F) m_wav0 <= 1'b0;
        end
        if (m_st1) begin
          m_hi <= m_hi + 1'b1;
          if (m_hi == 8'hFF) m_wav1 <= 1'b1; else if (m_hi == 8'h7F) m_wav1 <= 1'b0;
        end
        if (m_stn) begin
          n_cnt <= n_cnt + 1'b1;
          if (n_cnt == 16'hFFFF) n_wav <= 1'b1; else if (n_cnt == 16'h7FFF) n_wav <= 1'b0;
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "lo_count", lo_c, m_lo);
    chk("R5", "hi_count", hi_c, m_hi);
    chk("R4", "wav_out", wav_c, {m_wav1, m_wav0});
    chk("R6", "time_value", tv_c, {m_hi, m_lo});
    chk("R9", "rollover", roll_c, exp_roll);
    chk("R10", "native time_value", tv_n, n_cnt);
    chk("R10", "native lo_count", lo_n, n_cnt[W-1:0]);
    chk("R10", "native hi_count", hi_n, 0);
    chk("R10", "native wav_out", wav_n, {1'b0, n_wav});
    chk("R10", "native rollover", roll_n, exp_nroll);
    if (roll_c) n_roll++;
    if (roll_n) n_nroll++;
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse_sync();
    sync_cmd = 1'b1; tick_n(1); sync_cmd = 1'b0;
  endtask

  task automatic stable_read();
    logic [W-1:0]   h1, h2, l;
    logic [2*W-1:0] t;
    int tries;
    tries = 0;
    do begin
      tick_n(1); h1 = hi_c;
      tick_n(1); l = lo_c; t = tv_c;
      tick_n(1); h2 = hi_c;
      tries++;
    end while (h1 != h2 && tries < 4);
    chk("R11", "retrying split read", {h1, l}, t);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [W-1:0] v;
    checks = 0; fails = 0; cyc = 0; n_roll = 0; n_nroll = 0; done = 0;
    rst_n = 1'b0; sync_cmd = 1'b0; clk_start = '0; clk_stop = '0; presc_sel = '0;
    void'($urandom(32'h0C7B_51A5));

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "lo_count in reset", lo_c, 0);
    chk("R1", "hi_count in reset", hi_c, 0);
    chk("R1", "wav_out in reset", wav_c, 0);
    chk("R1", "rollover in reset", roll_c, 0);
    chk("R1", "native time_value in reset", tv_n, 0);
    rst_n = 1'b1;
    tick_n(10);
    chk("R1", "no counting before start", tv_c, 0);

    // R2/R5: divide by one, both channels running
    clk_start = 2'b11; tick_n(1); clk_start = '0;
    tick_n(600);
    chk("R2", "lo after 600 steps", lo_c, 600 % 256);
    chk("R5", "hi after 600 steps", hi_c, 2);

    // R3: prescaler intervals measured from a sync
    presc_sel = 2'd3; pulse_sync(); tick_n(64);
    chk("R3", "divide by 8 over 64 clocks", lo_c, 8);
    presc_sel = 2'd1; pulse_sync(); tick_n(64);
    chk("R3", "divide by 2 over 64 clocks", lo_c, 32);

    // R7: sync while running keeps run state
    presc_sel = 2'd0; tick_n(7);
    pulse_sync();
    chk("R7", "lo cleared by sync", lo_c, 0);
    chk("R7", "hi cleared by sync", hi_c, 0);
    tick_n(5);
    chk("R7", "still running after sync", lo_c, 5);

    // R8: stop freezes, start resumes, stop wins
    clk_stop = 2'b01; tick_n(1); clk_stop = '0;
    v = lo_c; tick_n(20);
    chk("R8", "frozen after stop", lo_c, v);
    clk_start = 2'b01; tick_n(1); clk_start = '0;
    tick_n(10);
    chk("R8", "resumed without clearing", lo_c, W'(v + 10));
    clk_start = 2'b01; clk_stop = 2'b01; tick_n(1); clk_start = '0; clk_stop = '0;
    v = lo_c; tick_n(10);
    chk("R8", "stop wins over start", lo_c, v);
    clk_start = 2'b01; tick_n(1); clk_start = '0;
    clk_stop = 2'b10; tick_n(1); clk_stop = '0;
    v = hi_c; tick_n(300);
    chk("R8", "stopped high half ignores wraps", hi_c, v);
    clk_start = 2'b10; tick_n(1); clk_start = '0;

    // R11: split read straddling a low-half wrap
    pulse_sync(); tick_n(253);
    stable_read();

    // mixed random commands
    for (int i = 0; i < 4000; i++) begin
      sync_cmd = ($urandom_range(199) == 0);
      for (int c = 0; c < 2; c++) begin
        clk_start[c] = ($urandom_range(15) == 0);
        clk_stop[c]  = ($urandom_range(39) == 0);
      end
      if ($urandom_range(127) == 0) presc_sel = SW'($urandom_range(3));
      tick_n(1);
      sync_cmd = 1'b0; clk_start = '0; clk_stop = '0;
      if (i % 250 == 249) stable_read();
    end

    // R9: full wrap of the composed value
    presc_sel = 2'd0;
    clk_start = 2'b11; tick_n(1); clk_start = '0;
    pulse_sync();
    n_roll = 0; n_nroll = 0;
    tick_n(65540);
    chk("R9", "one rollover pulse per wrap", n_roll, 1);
    chk("R9", "value after wrap", tv_c, 4);
    chk("R10", "native rollover pulse count", n_nroll, 1);
    chk("R10", "native value after wrap", tv_n, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule